// File: doc/BRIEF.md
# SPI Slave Byte Exchange Engine

This block is the serial engine of an SPI slave. While chip select is held low by an external master, it exchanges bytes in both directions. Transmit bytes are fetched from a byte-wide read port into a shift register. Completed receive bytes are written out through a byte-wide write port at consecutive addresses, starting from zero.

Each transaction runs from the falling edge of chip select to its rising edge. Software sets separate limits on how many bytes may be taken from the transmit buffer and how many may be stored in the receive buffer. Beyond the transmit limit, the engine sends a programmable fill byte and flags an over-read. Beyond the receive limit, it discards bytes and flags an overflow. When the engine is not granted the buffers at the start of a transaction, it sends a default byte and leaves the buffers alone.

The serial clock, chip select and data-in lines are synchronised into the system clock domain. The system clock must run at least four times faster than the serial clock.

Top module: `spi_slave_xfer`

## Requirements
- R1: The serial clock polarity (`cpol_i`) and phase (`cpha_i`) select the four clock modes. With `cpha_i`=0, data is sampled on the leading edge, which is the first edge away from the idle level set by `cpol_i`. With `cpha_i`=1, data is sampled on the trailing edge.
- R2: With `lsb_first_i`=1, bit 0 of each byte is shifted first in both directions. With `lsb_first_i`=0, bit 7 is shifted first.
- R3: The first transmit byte is loaded when chip select falls, so its first bit is on `miso_o` before the first serial clock edge.
- R4: In a granted transaction, transmit byte k (counting from 0) is read from address k of the transmit port, for every k below the transmit limit.
- R5: In a granted transaction, every byte past the transmit limit sends `orc_i` instead. Completing such a byte sets `overread_o`.
- R6: In a granted transaction, received byte k is written to address k while k is below the receive limit. Later bytes are not written, and completing one sets `overflow_o`.
- R7: In a transaction begun with `granted_i`=0, every byte sent is `def_i`. No receive write occurs, both amounts read 0 afterwards, the flags keep their values, and no end pulse is given.
- R8: The amounts report how many whole bytes came from the transmit buffer and how many were written to the receive buffer. They are cleared when chip select falls. A partial byte at deassertion is not counted.
- R9: `end_o` pulses for exactly one cycle after chip select rises at the close of a granted transaction.
- R10: `overread_o` and `overflow_o` stay set until a one is applied on their own clear input, and each clear affects only its own flag.
- R11: After reset, the amounts, the flags, `end_o`, `rx_wr_en_o` and `tx_rd_addr_o` are 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| lsb_first_i | input | 1 | Bit order for both directions |
| granted_i | input | 1 | Buffers are owned by the engine; sampled when chip select falls |
| tx_max_i | input | CNT_W | Transmit byte limit |
| rx_max_i | input | CNT_W | Receive byte limit |
| orc_i | input | 8 | Fill byte sent past the transmit limit |
| def_i | input | 8 | Byte sent when not granted |
| clr_overread_i | input | 1 | Write-one clear of the over-read flag |
| clr_overflow_i | input | 1 | Write-one clear of the overflow flag |
| sck_i | input | 1 | Serial clock from the master |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| tx_rd_addr_o | output | CNT_W | Transmit buffer read address |
| tx_rd_data_i | input | 8 | Transmit buffer read data for the current address |
| rx_wr_en_o | output | 1 | Receive buffer write strobe |
| rx_wr_addr_o | output | CNT_W | Receive buffer write address |
| rx_wr_data_o | output | 8 | Receive buffer write data |
| tx_amount_o | output | CNT_W | Bytes taken from the transmit buffer |
| rx_amount_o | output | CNT_W | Bytes written to the receive buffer |
| end_o | output | 1 | Granted transaction finished |
| overread_o | output | 1 | Sticky over-read flag |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
A bit counter that has slipped, or a byte loaded one edge too early or too late, shows on `miso_o` within the same byte: the master captures a rotated or shifted value at the next byte boundary. An index that is off by one against a limit shows in several places once the transaction closes: a wrong fill byte, a stray or missing write at the receive port, an amount one off, or a flag raised without cause. A grant latched at the wrong time shows either as default bytes in a granted run or as writes in an ungranted one.

// File: rtl/spis_pkg.sv
package spis_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);

  typedef logic [BYTE_W-1:0] byte_t;

  // one-cycle events in the system clock domain
  typedef struct packed {
    logic sel_fall;
    logic sel_rise;
    logic sample;
    logic shift;
  } spis_ev_t;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int unsigned    W       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge
  import spis_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sck_i,
  input  logic     csn_i,
  input  logic     cpol_i,
  input  logic     cpha_i,
  output spis_ev_t ev_o
);
  logic sck_q, csn_q;
  logic sck_n, sck_nq, lead, trail, live;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= sck_i;
      csn_q <= csn_i;
    end

  // normalise so that the leading edge is always a rise
  assign sck_n  = sck_i ^ cpol_i;
  assign sck_nq = sck_q ^ cpol_i;
  assign lead   = sck_n & ~sck_nq;
  assign trail  = ~sck_n & sck_nq;
  assign live   = ~csn_i & ~csn_q;

  assign ev_o.sel_fall = csn_q & ~csn_i;
  assign ev_o.sel_rise = ~csn_q & csn_i;
  assign ev_o.sample   = live & (cpha_i ? trail : lead);
  assign ev_o.shift    = live & (cpha_i ? lead : trail);

  // R1
  edge_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_o.sel_fall, ev_o.sel_rise, ev_o.sample, ev_o.shift}));
endmodule

// File: rtl/spi_slave_xfer.sv
module spi_slave_xfer
  import spis_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             lsb_first_i,
  input  logic             granted_i,
  input  logic [CNT_W-1:0] tx_max_i,
  input  logic [CNT_W-1:0] rx_max_i,
  input  logic [7:0]       orc_i,
  input  logic [7:0]       def_i,
  input  logic             clr_overread_i,
  input  logic             clr_overflow_i,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic [CNT_W-1:0] tx_rd_addr_o,
  input  logic [7:0]       tx_rd_data_i,
  output logic             rx_wr_en_o,
  output logic [CNT_W-1:0] rx_wr_addr_o,
  output logic [7:0]       rx_wr_data_o,
  output logic [CNT_W-1:0] tx_amount_o,
  output logic [CNT_W-1:0] rx_amount_o,
  output logic             end_o,
  output logic             overread_o,
  output logic             overflow_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic     sck_s, csn_s, mosi_s;
  spis_ev_t ev;

  spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, csn_i, mosi_i}),
    .q_o   ({sck_s, csn_s, mosi_s})
  );

  spis_edge i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sck_i (sck_s),
    .csn_i (csn_s),
    .cpol_i(cpol_i),
    .cpha_i(cpha_i),
    .ev_o  (ev)
  );

  logic                 in_xfer, grant_q, pend, cur_fill;
  logic [CNT_W-1:0]     tx_max_q, rx_max_q, tx_idx, tx_amt, rx_amt;
  logic [BIT_CNT_W-1:0] bit_cnt;
  byte_t                tx_sh, rx_sh;

  logic             grant_now, fill_now, byte_end, rx_room, set_rd, set_fl;
  logic [CNT_W-1:0] max_now, tx_idx_inc;
  byte_t            load_byte, rx_next;

  assign grant_now  = ev.sel_fall ? granted_i : grant_q;
  assign max_now    = ev.sel_fall ? tx_max_i : tx_max_q;
  assign fill_now   = tx_idx >= max_now;
  assign load_byte  = !grant_now ? def_i : (fill_now ? orc_i : tx_rd_data_i);
  assign rx_next    = lsb_first_i ? {mosi_s, rx_sh[BYTE_W-1:1]} : {rx_sh[BYTE_W-2:0], mosi_s};
  assign byte_end   = in_xfer && ev.sample && bit_cnt == LAST_BIT;
  assign rx_room    = rx_amt < rx_max_q;
  assign tx_idx_inc = (&tx_idx) ? tx_idx : tx_idx + 1'b1;
  assign set_rd     = byte_end && grant_q && cur_fill;
  assign set_fl     = byte_end && grant_q && !rx_room;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      in_xfer    <= 1'b0;
      grant_q    <= 1'b0;
      tx_max_q   <= '0;
      rx_max_q   <= '0;
      bit_cnt    <= '0;
      pend       <= 1'b0;
      tx_sh      <= '0;
      cur_fill   <= 1'b0;
      rx_sh      <= '0;
      tx_idx     <= '0;
      tx_amt     <= '0;
      rx_amt     <= '0;
      rx_wr_en_o <= 1'b0;
      rx_wr_addr_o <= '0;
      rx_wr_data_o <= '0;
      end_o      <= 1'b0;
    end else begin
      rx_wr_en_o <= 1'b0;
      end_o      <= 1'b0;
      if (ev.sel_fall) begin
        in_xfer  <= 1'b1;
        grant_q  <= granted_i;
        tx_max_q <= tx_max_i;
        rx_max_q <= rx_max_i;
        bit_cnt  <= '0;
        pend     <= 1'b0;
        tx_sh    <= load_byte;
        cur_fill <= fill_now;
        tx_idx   <= tx_idx_inc;
        tx_amt   <= '0;
        rx_amt   <= '0;
      end else if (in_xfer) begin
        if (ev.sel_rise) begin
          in_xfer <= 1'b0;
          tx_idx  <= '0;
          end_o   <= grant_q;
        end else if (ev.sample) begin
          rx_sh   <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (byte_end) begin
            pend <= 1'b1;
            if (grant_q) begin
              if (!cur_fill) tx_amt <= tx_amt + 1'b1;
              if (rx_room) begin
                rx_wr_en_o   <= 1'b1;
                rx_wr_addr_o <= rx_amt;
                rx_wr_data_o <= rx_next;
                rx_amt       <= rx_amt + 1'b1;
              end
            end
          end
        end else if (ev.shift) begin
          if (pend) begin
            tx_sh    <= load_byte;
            cur_fill <= fill_now;
            tx_idx   <= tx_idx_inc;
            pend     <= 1'b0;
          end else if (bit_cnt != '0) begin
            tx_sh <= lsb_first_i ? {1'b0, tx_sh[BYTE_W-1:1]} : {tx_sh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      overread_o <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      overread_o <= set_rd | (overread_o & ~clr_overread_i);
      overflow_o <= set_fl | (overflow_o & ~clr_overflow_i);
    end

  assign miso_o       = lsb_first_i ? tx_sh[0] : tx_sh[BYTE_W-1];
  assign tx_rd_addr_o = tx_idx;
  assign tx_amount_o  = tx_amt;
  assign rx_amount_o  = rx_amt;

  // R6
  rx_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_wr_en_o |-> rx_wr_addr_o < rx_max_q);
  // R7
  no_ungranted_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_wr_en_o |-> grant_q);
  // R8
  amt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_amount_o <= tx_max_q && rx_amount_o <= rx_max_q);
  // R9
  end_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);
  // R10
  overread_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overread_o && !clr_overread_i |=> overread_o);
  // R10
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !clr_overflow_i |=> overflow_o);
endmodule

// File: tb/test_spi_slave_xfer.sv
module test_spi_slave_xfer;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cpol = 0, cpha = 0, lsb = 0, granted = 0;
  logic [7:0] tx_max = 0, rx_max = 0, orc = 8'hF0, def = 8'h0D;
  logic clr_rd = 0, clr_fl = 0, sck = 0, csn = 1, mosi = 0, miso;
  logic [7:0] tx_addr, tx_data, rx_addr, rx_data, tx_amt, rx_amt;
  logic rx_we, end_p, ovr_rd, ovr_fl;

  logic [7:0] tx_mem [16];
  logic [7:0] rx_mem [16];
  logic [7:0] mosi_b [16];
  logic [7:0] miso_cap [16];
  logic prefill = 0;
  int n_chk = 0, n_fail = 0, end_cnt = 0;

  assign tx_data = tx_mem[tx_addr[3:0]];
  always @(posedge clk) begin
    if (prefill) for (int i = 0; i < 16; i++) rx_mem[i] <= 8'hEE;
    else if (rx_we) rx_mem[rx_addr[3:0]] <= rx_data;
    if (end_p) end_cnt <= end_cnt + 1;
  end

  spi_slave_xfer i_spi_slave_xfer (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsb),
    .granted_i(granted), .tx_max_i(tx_max), .rx_max_i(rx_max), .orc_i(orc), .def_i(def),
    .clr_overread_i(clr_rd), .clr_overflow_i(clr_fl), .sck_i(sck), .csn_i(csn),
    .mosi_i(mosi), .miso_o(miso), .tx_rd_addr_o(tx_addr), .tx_rd_data_i(tx_data),
    .rx_wr_en_o(rx_we), .rx_wr_addr_o(rx_addr), .rx_wr_data_o(rx_data),
    .tx_amount_o(tx_amt), .rx_amount_o(rx_amt), .end_o(end_p),
    .overread_o(ovr_rd), .overflow_o(ovr_fl)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // master: nbits serial clocks, data from mosi_b, capture into miso_cap
  task automatic run_xfer(input int nbits);
    sck = cpol;
    wait_n(2);
    csn = 1'b0;
    wait_n(8);
    for (int k = 0; k < nbits; k++) begin
      int bi  = k / 8;
      int pos = lsb ? (k % 8) : 7 - (k % 8);
      if (!cpha) begin
        mosi = mosi_b[bi][pos];
        wait_n(4);
        miso_cap[bi][pos] = miso;
        sck = ~cpol;
        wait_n(4);
        sck = cpol;
      end else begin
        sck = ~cpol;
        wait_n(3);
        mosi = mosi_b[bi][pos];
        wait_n(1);
        miso_cap[bi][pos] = miso;
        sck = cpol;
        wait_n(4);
      end
    end
    wait_n(4);
    csn = 1'b1;
    wait_n(10);
  endtask

  task automatic clear_flags();
    clr_rd = 1; clr_fl = 1;
    wait_n(1);
    clr_rd = 0; clr_fl = 0;
  endtask

  task automatic prep(input int seed);
    for (int i = 0; i < 16; i++) begin
      tx_mem[i]   = 8'h5A ^ 8'(i * 19) ^ 8'(seed);
      mosi_b[i]   = 8'hC3 + 8'(i * 37) + 8'(seed * 11);
      miso_cap[i] = 8'h00;
    end
    prefill = 1;
    wait_n(1);
    prefill = 0;
  endtask

  typedef struct packed {
    logic [1:0] mode;
    logic       lsb;
    logic       grant;
    logic [7:0] txm;
    logic [7:0] rxm;
    logic [3:0] n;
  } vec_t;

  // R1 R2 R3: every mode and both orders; R4 R5 R6 R7 R8 R9 by limits and grant
  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b0, 1'b1, 8'd4, 8'd4, 4'd3},
    '{2'd1, 1'b0, 1'b1, 8'd4, 8'd4, 4'd4},
    '{2'd2, 1'b1, 1'b1, 8'd2, 8'd5, 4'd4},
    '{2'd3, 1'b1, 1'b1, 8'd5, 8'd2, 4'd4},
    '{2'd0, 1'b1, 1'b0, 8'd4, 8'd4, 4'd3},
    '{2'd3, 1'b0, 1'b1, 8'd0, 8'd0, 4'd2},
    '{2'd1, 1'b1, 1'b1, 8'd3, 8'd3, 4'd3},
    '{2'd2, 1'b0, 1'b1, 8'd6, 8'd1, 4'd5}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_n(3);
    // R11 reset state
    check("R11 tx_amount", tx_amt, 0);
    check("R11 rx_amount", rx_amt, 0);
    check("R11 flags", {ovr_rd, ovr_fl}, 0);
    check("R11 end/wr", {end_p, rx_we}, 0);
    check("R11 tx_rd_addr", tx_addr, 0);
    rst_n = 1'b1;
    wait_n(3);

    foreach (VECS[v]) begin
      vec_t c = VECS[v];
      int   e0, n_tx, n_rx;
      prep(v);
      clear_flags();
      cpol = c.mode[1]; cpha = c.mode[0]; lsb = c.lsb; granted = c.grant;
      tx_max = c.txm; rx_max = c.rxm;
      e0 = end_cnt;
      run_xfer(int'(c.n) * 8);
      n_tx = c.grant ? ((c.n < c.txm) ? int'(c.n) : int'(c.txm)) : 0;
      n_rx = c.grant ? ((c.n < c.rxm) ? int'(c.n) : int'(c.rxm)) : 0;
      for (int i = 0; i < int'(c.n); i++) begin
        if (!c.grant)           check("R7 default byte", miso_cap[i], def);
        else if (i >= int'(c.txm)) check("R5 fill byte", miso_cap[i], orc);
        else                    check("R4 tx byte", miso_cap[i], tx_mem[i]);
      end
      for (int i = 0; i < 8; i++)
        check(c.grant ? "R6 rx store" : "R7 no store", rx_mem[i],
              (i < n_rx) ? int'(mosi_b[i]) : 8'hEE);
      check("R8 tx amount", tx_amt, n_tx);
      check("R8 rx amount", rx_amt, n_rx);
      check("R5 overread", ovr_rd, int'(c.grant && c.n > c.txm));
      check("R6 overflow", ovr_fl, int'(c.grant && c.n > c.rxm));
      check("R9 end pulses", end_cnt - e0, int'(c.grant));
    end

    // R8 partial byte dropped
    prep(9);
    cpol = 0; cpha = 1; lsb = 0; granted = 1; tx_max = 4; rx_max = 4;
    run_xfer(2 * 8 + 5);
    check("R8 partial tx amount", tx_amt, 2);
    check("R8 partial rx amount", rx_amt, 2);
    check("R8 partial not stored", rx_mem[2], 8'hEE);

    // R10 sticky flags, R7 ungranted leaves them
    prep(3);
    clear_flags();
    tx_max = 0; rx_max = 0;
    run_xfer(8);
    check("R10 overread set", ovr_rd, 1);
    check("R10 overflow set", ovr_fl, 1);
    granted = 0;
    run_xfer(16);
    check("R7 flags untouched", {ovr_rd, ovr_fl}, 2'b11);
    check("R7 amounts cleared", {tx_amt, rx_amt}, 0);
    wait_n(20);
    check("R10 still set", {ovr_rd, ovr_fl}, 2'b11);
    clr_fl = 1; wait_n(1); clr_fl = 0; wait_n(1);
    check("R10 clear overflow only", {ovr_rd, ovr_fl}, 2'b10);
    clr_rd = 1; wait_n(1); clr_rd = 0; wait_n(1);
    check("R10 clear overread", {ovr_rd, ovr_fl}, 2'b00);

    // R3 first bit ready before any clock, mode 2 msb
    prep(5);
    cpol = 1; cpha = 0; lsb = 0; granted = 1; tx_max = 2;
    sck = 1; wait_n(2); csn = 0; wait_n(8);
    check("R3 first bit", miso, int'(tx_mem[0][7]));
    csn = 1; wait_n(10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule